// File: doc/BRIEF.md
# Banked GPIO Controller with Function Select

This block controls up to 64 general-purpose pins through a word-wide register bus. The pins are split into 32-bit banks, and every register repeats once per bank. Software drives the pin outputs in three ways: it can set bits with a write-one word, clear bits with a write-one word, or write the whole output value. It also sets the pin directions, reads back the sampled pin levels, and gives each pin a two-bit function index that chooses between GPIO and three alternate functions.

Each pin has interrupt detection. A per-pin mode bit chooses between detection on both edges and detection while the level is high. Each detected event sets a sticky pending flag. An enable mask turns the pending flags into identity bits, and the OR of all identity bits drives one interrupt line.

The bus is a single-cycle write strobe with a combinational read path. Pin inputs pass through a two-flop synchroniser before they are sampled or used for detection.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: The bank count S is 1 + (NPINS-1)/32. A register with byte base B places bank b at byte address B*S + 4*b, and pin p sits in bank p/32 at bit p%32. The byte bases are: set 0x00, clear 0x04, value 0x08, input 0x0C, direction 0x10, pending 0x14, enable 0x18, identity 0x1C, drive-map 0x28 and trigger-mode 0x2C. Any address outside these regions reads zero.
- R2: Writing ones to the set word raises those output bits, and writing ones to the clear word lowers them. Zero bits in either word leave their outputs unchanged. Both words read as zero. Writing the value word loads it directly and reading it returns the outputs. `pin_out` follows one clock after the write.
- R3: A direction bit of 1 makes the pin an output and a 0 makes it an input. `pin_oe` follows the direction word one clock after the write, and the word reads back.
- R4: The input word returns the pin levels after a two-flop synchroniser. A change becomes visible after the second rising edge that follows it.
- R5: Bit 0 of each function index sits in the low select word at byte 0x20*S + 8*b. Bit 1 sits in the high select word at 0x20*S + 8*b + 4, both at bit p%32. `pin_func[2p+1:2p]` equals {high, low}, and index 0 means GPIO.
- R6: With trigger-mode bit 0, a rising or a falling synchronised level sets the pending bit. The bit reads as set after the third rising edge following the pin change, and not before.
- R7: With trigger-mode bit 1, the pending bit is set on every cycle that the synchronised level is high, so a clear does not hold while the pin stays high. A falling level does not set the bit.
- R8: Writing a one to a pending bit clears it, and zero bits have no effect. An event in the same cycle as the clear leaves the bit set.
- R9: The identity word reads as pending AND enable and ignores writes. `irq` is the OR of all identity bits.
- R10: The drive-map word is plain read/write storage and has no effect on any output.
- R11: Bits at or above NPINS in the last bank read as zero and ignore writes in every register.
- R12: Reset, synchronous and active low, clears the outputs, directions, enables, pending flags, trigger modes, function selects and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pin_in | input | NPINS | Raw pin levels |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output enable per pin |
| pin_func | output | 2*NPINS | Function index per pin, two bits each |
| irq | output | 1 | Combined interrupt |

## Verification
The bench uses 40 pins, so the second bank is only partly populated. This exposes designs that keep state or return data in the eight-bit tail's unused bits. A decoder that gets the bank stride or the interleaved select words wrong shows up as a pin sweep over every pin: the wrong pin's output or function index changes.

Interrupt detection is timed to the exact rising edge. A missing synchroniser stage makes the flag appear one cycle early, and a detector that sees only rising edges misses the falling-edge case. The bench also times a clear to land in the same cycle as a new event, where a clear-wins design would lose the flag. In level mode it checks that a clear does not hold while the pin stays high. Finally, writes to the identity word must not change the pending state, and a pending flag with no enable must not raise the interrupt.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Width of one bank word
    localparam int unsigned WORD_W = 32;

    // Register byte bases, before scaling by the bank count
    localparam int unsigned BASE_OSET  = 'h00;
    localparam int unsigned BASE_OCLR  = 'h04;
    localparam int unsigned BASE_OVAL  = 'h08;
    localparam int unsigned BASE_INP   = 'h0C;
    localparam int unsigned BASE_OE    = 'h10;
    localparam int unsigned BASE_PEND  = 'h14;
    localparam int unsigned BASE_ENA   = 'h18;
    localparam int unsigned BASE_IDENT = 'h1C;
    localparam int unsigned BASE_ALT   = 'h20;
    localparam int unsigned BASE_DRV   = 'h28;
    localparam int unsigned BASE_TRIG  = 'h2C;

    // Register selector produced by the address decoder
    typedef enum logic [3:0] {
        SEL_NONE, SEL_OSET, SEL_OCLR, SEL_OVAL, SEL_INP, SEL_OE,
        SEL_PEND, SEL_ENA, SEL_IDENT, SEL_ALT, SEL_DRV, SEL_TRIG
    } reg_sel_e;

    // Number of 32-bit banks needed for a pin count
    function automatic int unsigned bank_count(input int unsigned npins);
        return 1 + (npins - 1) / WORD_W;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
// Two-flop synchroniser for the raw pin levels.
// Assumes: each pin is an independent level; no bus coherency across pins is needed.
module gpio_in_sync #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1_q;

    // Shift the pin levels through two flops
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '0;
            q        <= '0;
        end else begin
            stage1_q <= d;
            q        <= stage1_q;
        end
    end
endmodule

// File: rtl/gpio_addr_decode.sv
// Turns a byte address into a register selector, a bank index and the select-word half.
// Assumes: a bank count of one or two (at most 64 pins), and word-aligned accesses.
module gpio_addr_decode
    import gpio_pkg::*;
#(
    parameter int unsigned S      = 2,
    parameter int unsigned ADDR_W = 8,
    localparam int unsigned BANK_W = (S > 1) ? $clog2(S) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel,
    output logic [BANK_W-1:0] bank,
    output logic              alt_hi
);
    // Word index, register region (word base) and offset within the region
    always_comb begin
        int unsigned wi;
        int unsigned region;
        int unsigned sub;
        int unsigned off;
        wi     = int'(addr) / 4;
        region = wi / S;
        sub    = wi % S;
        off    = 0;
        sel    = SEL_NONE;
        bank   = BANK_W'(sub);
        alt_hi = 1'b0;
        case (region)
            BASE_OSET  / 4: sel = SEL_OSET;
            BASE_OCLR  / 4: sel = SEL_OCLR;
            BASE_OVAL  / 4: sel = SEL_OVAL;
            BASE_INP   / 4: sel = SEL_INP;
            BASE_OE    / 4: sel = SEL_OE;
            BASE_PEND  / 4: sel = SEL_PEND;
            BASE_ENA   / 4: sel = SEL_ENA;
            BASE_IDENT / 4: sel = SEL_IDENT;
            BASE_ALT / 4, BASE_ALT / 4 + 1: begin
                off    = wi - (BASE_ALT / 4) * S;
                sel    = SEL_ALT;
                bank   = BANK_W'(off / 2);
                alt_hi = (off % 2) == 1;
            end
            BASE_DRV   / 4: sel = SEL_DRV;
            BASE_TRIG  / 4: sel = SEL_TRIG;
            default:        sel = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank.sv
// Interrupt detection for one 32-pin bank: both-edge or level-high per pin, sticky pending flags.
// Assumes: level is already synchronised; clr is a one-cycle write-one-to-clear mask.
module gpio_irq_bank
    import gpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] level,
    input  logic [WORD_W-1:0] valid,
    input  logic [WORD_W-1:0] trig_lvl,
    input  logic [WORD_W-1:0] ena,
    input  logic [WORD_W-1:0] clr,
    output logic [WORD_W-1:0] pend,
    output logic [WORD_W-1:0] ident,
    output logic              any
);
    logic [WORD_W-1:0] prev_q;
    logic [WORD_W-1:0] evt;

    // Keep the previous synchronised level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= level;
    end

    // An event is a high level in level mode, or any change in edge mode
    assign evt = valid & ((trig_lvl & level) | (~trig_lvl & (level ^ prev_q)));

    // Sticky pending flags; a new event beats a simultaneous clear
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= ((pend & ~clr) | evt) & valid;
    end

    assign ident = pend & ena;
    assign any   = |ident;

    AST_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(evt)) == $past(evt))); // R6

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & $past(clr & ~evt)) == '0)); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(evt)) == '0)); // R7
endmodule

// File: rtl/gpio_bank_ctrl.sv
// Banked GPIO controller: output set/clear/value, direction, input sampling,
// two-bit function select and edge/level interrupts behind a word register bus.
// Assumes: 1 <= NPINS <= 64, one bus write per cycle, combinational read data.
module gpio_bank_ctrl
    import gpio_pkg::*;
#(
    parameter int unsigned NPINS  = 40,
    parameter int unsigned ADDR_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [WORD_W-1:0]    bus_wdata,
    output logic [WORD_W-1:0]    bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    output logic [2*NPINS-1:0]   pin_func,
    output logic                 irq
);
    localparam int unsigned S      = bank_count(NPINS);
    localparam int unsigned PAD    = S * WORD_W;
    localparam int unsigned BANK_W = (S > 1) ? $clog2(S) : 1;

    // Valid-pin mask across all banks
    function automatic logic [PAD-1:0] valid_bits();
        logic [PAD-1:0] m;
        for (int i = 0; i < PAD; i++) m[i] = (i < NPINS);
        return m;
    endfunction
    localparam logic [PAD-1:0] VALID = valid_bits();

    typedef logic [S-1:0][WORD_W-1:0] bank_arr_t;

    bank_arr_t vmask;
    bank_arr_t out_q, oe_q, ena_q, alt_lo_q, alt_hi_q, drv_q, trig_q;
    bank_arr_t in_arr, pend_w, ident_w;
    bank_arr_t set_req, oclr_req, pclr_req;
    logic [S-1:0]       any_w;
    logic [NPINS-1:0]   pin_sync;
    reg_sel_e           sel;
    logic [BANK_W-1:0]  bank;
    logic               alt_hi;

    assign vmask = VALID;

    gpio_addr_decode #(.S(S), .ADDR_W(ADDR_W)) u_dec (
        .addr   (bus_addr),
        .sel    (sel),
        .bank   (bank),
        .alt_hi (alt_hi)
    );

    gpio_in_sync #(.W(NPINS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (pin_sync)
    );

    assign in_arr = PAD'(pin_sync);

    // Per-write masks for output set, output clear and pending clear
    always_comb begin
        set_req  = '0;
        oclr_req = '0;
        pclr_req = '0;
        if (bus_wr) begin
            case (sel)
                SEL_OSET: set_req[bank]  = bus_wdata & vmask[bank];
                SEL_OCLR: oclr_req[bank] = bus_wdata & vmask[bank];
                SEL_PEND: pclr_req[bank] = bus_wdata & vmask[bank];
                default:  ;
            endcase
        end
    end

    // Control registers, updated by bus writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q    <= '0;
            oe_q     <= '0;
            ena_q    <= '0;
            alt_lo_q <= '0;
            alt_hi_q <= '0;
            drv_q    <= '0;
            trig_q   <= '0;
        end else begin
            out_q <= (out_q | set_req) & ~oclr_req;
            if (bus_wr) begin
                case (sel)
                    SEL_OVAL: out_q[bank] <= bus_wdata & vmask[bank];
                    SEL_OE:   oe_q[bank]  <= bus_wdata & vmask[bank];
                    SEL_ENA:  ena_q[bank] <= bus_wdata & vmask[bank];
                    SEL_DRV:  drv_q[bank] <= bus_wdata & vmask[bank];
                    SEL_TRIG: trig_q[bank] <= bus_wdata & vmask[bank];
                    SEL_ALT: begin
                        if (alt_hi) alt_hi_q[bank] <= bus_wdata & vmask[bank];
                        else        alt_lo_q[bank] <= bus_wdata & vmask[bank];
                    end
                    default: ;
                endcase
            end
        end
    end

    // One interrupt detector per bank
    for (genvar b = 0; b < S; b++) begin : g_bank
        gpio_irq_bank u_irq (
            .clk      (clk),
            .rst_n    (rst_n),
            .level    (in_arr[b]),
            .valid    (vmask[b]),
            .trig_lvl (trig_q[b]),
            .ena      (ena_q[b]),
            .clr      (pclr_req[b]),
            .pend     (pend_w[b]),
            .ident    (ident_w[b]),
            .any      (any_w[b])
        );
    end

    assign irq = |any_w;

    // Read-data multiplexer
    always_comb begin
        case (sel)
            SEL_OVAL:  bus_rdata = out_q[bank];
            SEL_INP:   bus_rdata = in_arr[bank];
            SEL_OE:    bus_rdata = oe_q[bank];
            SEL_PEND:  bus_rdata = pend_w[bank];
            SEL_ENA:   bus_rdata = ena_q[bank];
            SEL_IDENT: bus_rdata = ident_w[bank];
            SEL_ALT:   bus_rdata = alt_hi ? alt_hi_q[bank] : alt_lo_q[bank];
            SEL_DRV:   bus_rdata = drv_q[bank];
            SEL_TRIG:  bus_rdata = trig_q[bank];
            default:   bus_rdata = '0;
        endcase
    end

    assign pin_out = NPINS'(out_q);
    assign pin_oe  = NPINS'(oe_q);

    // Two-bit function index per pin from the interleaved select words
    for (genvar p = 0; p < NPINS; p++) begin : g_func
        assign pin_func[2*p+1:2*p] = {alt_hi_q[p/WORD_W][p%WORD_W],
                                      alt_lo_q[p/WORD_W][p%WORD_W]};
    end

    AST_OSET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((out_q & $past(set_req)) == $past(set_req))); // R2

    AST_OCLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((out_q & $past(oclr_req)) == '0)); // R2

    AST_IRQ_NEEDS_ENA: assert property (@(posedge clk) disable iff (!rst_n)
        (ena_q == '0) |-> !irq); // R9

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (pin_out == '0 && pin_oe == '0 && pin_func == '0)); // R12
endmodule

// File: tb/gpio_bank_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_bank_ctrl_bench;
    localparam int NP = 40;
    localparam int S  = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_in = '0;
    logic [NP-1:0]     pin_out;
    logic [NP-1:0]     pin_oe;
    logic [2*NP-1:0]   pin_func;
    logic              irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    gpio_bank_ctrl #(.NPINS(NP), .ADDR_W(8)) u_gpio_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_func(pin_func), .irq(irq)
    );

    function automatic logic [7:0] ra(input int base, input int b);
        return 8'(base * S + 4 * b);
    endfunction
    function automatic logic [7:0] ra_alt(input int b, input int hi);
        return 8'('h20 * S + 8 * b + 4 * hi);
    endfunction

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; the write lands on the next rising edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic clear_all();
        wr(ra('h14, 0), 32'hFFFF_FFFF);
        wr(ra('h14, 1), 32'hFFFF_FFFF);
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [NP-1:0] out_m;
        logic [NP-1:0] oe_m;
        logic [31:0]   v;
        logic [31:0]   lo [S];
        logic [31:0]   hi [S];

        step(3);
        rst_n = 1'b1;
        step(1);

        // R12: reset state
        chk("R12", "pin_out", 64'(pin_out), 64'h0);
        chk("R12", "pin_oe", 64'(pin_oe), 64'h0);
        chk("R12", "pin_func", 64'(pin_func[63:0]) | 64'(pin_func[79:64]), 64'h0);
        chk("R12", "irq", 64'(irq), 64'h0);
        for (int b = 0; b < S; b++) begin
            rd(ra('h08, b), v); chk("R12", "value word", 64'(v), 64'h0);
            rd(ra('h10, b), v); chk("R12", "direction word", 64'(v), 64'h0);
            rd(ra('h14, b), v); chk("R12", "pending word", 64'(v), 64'h0);
            rd(ra('h18, b), v); chk("R12", "enable word", 64'(v), 64'h0);
            rd(ra('h2C, b), v); chk("R12", "trigger word", 64'(v), 64'h0);
            rd(ra_alt(b, 0), v); chk("R12", "select low", 64'(v), 64'h0);
            rd(ra_alt(b, 1), v); chk("R12", "select high", 64'(v), 64'h0);
        end
        step(1);

        // R1 R2: set sweep over every pin, then clear sweep
        out_m = '0;
        for (int p = 0; p < NP; p++) begin
            if (p % 3 != 1) begin
                wr(ra('h00, p / 32), 32'(1) << (p % 32));
                out_m[p] = 1'b1;
                chk("R1 R2", $sformatf("set pin %0d", p), 64'(pin_out), 64'(out_m));
            end
        end
        for (int p = 0; p < NP; p++) begin
            if (p % 5 == 0) begin
                wr(ra('h04, p / 32), 32'(1) << (p % 32));
                out_m[p] = 1'b0;
                chk("R2", $sformatf("clear pin %0d", p), 64'(pin_out), 64'(out_m));
            end
        end
        rd(ra('h00, 0), v); chk("R2", "set word reads zero", 64'(v), 64'h0);
        rd(ra('h04, 1), v); chk("R2", "clear word reads zero", 64'(v), 64'h0);
        rd(ra('h08, 0), v); chk("R2", "value bank0", 64'(v), 64'(out_m[31:0]));
        rd(ra('h08, 1), v); chk("R2", "value bank1", 64'(v), 64'(out_m[39:32]));
        step(1);
        wr(ra('h08, 0), 32'hA5A5_0F0F);
        out_m[31:0] = 32'hA5A5_0F0F;
        chk("R2", "value write", 64'(pin_out), 64'(out_m));

        // R11: unused tail bits and unmapped addresses
        wr(ra('h08, 1), 32'hFFFF_FFFF);
        out_m[39:32] = 8'hFF;
        rd(ra('h08, 1), v); chk("R11", "value tail masked", 64'(v), 64'h0000_00FF);
        chk("R11", "pin_out after tail write", 64'(pin_out), 64'(out_m));
        rd(8'h60, v); chk("R11", "unmapped 0x60", 64'(v), 64'h0);
        rd(8'hFC, v); chk("R11", "unmapped 0xFC", 64'(v), 64'h0);
        step(1);

        // R3: direction words
        wr(ra('h10, 0), 32'h1234_5678);
        wr(ra('h10, 1), 32'hFFFF_FF3C);
        oe_m = {8'h3C, 32'h1234_5678};
        chk("R3", "pin_oe", 64'(pin_oe), 64'(oe_m));
        rd(ra('h10, 1), v); chk("R3 R11", "direction bank1", 64'(v), 64'h3C);
        step(1);

        // R5: function index per pin, index = p%4
        for (int b = 0; b < S; b++) begin
            lo[b] = '0; hi[b] = '0;
            for (int i = 0; i < 32; i++) begin
                if (b * 32 + i < NP) begin
                    lo[b][i] = ((b * 32 + i) % 4) & 1;
                    hi[b][i] = (((b * 32 + i) % 4) >> 1) & 1;
                end
            end
        end
        wr(ra_alt(0, 0), lo[0]);
        wr(ra_alt(0, 1), hi[0]);
        wr(ra_alt(1, 0), lo[1] | 32'hFFFF_FF00);
        wr(ra_alt(1, 1), hi[1] | 32'hFFFF_FF00);
        for (int p = 0; p < NP; p++)
            chk("R1 R5", $sformatf("func pin %0d", p), 64'(pin_func[2*p +: 2]), 64'(p % 4));
        rd(ra_alt(1, 0), v); chk("R5 R11", "select low bank1", 64'(v), 64'(lo[1]));
        rd(ra_alt(1, 1), v); chk("R5 R11", "select high bank1", 64'(v), 64'(hi[1]));
        step(1);
        wr(ra_alt(0, 1), 32'h0);
        for (int p = 0; p < 32; p++)
            chk("R5", $sformatf("func pin %0d high cleared", p), 64'(pin_func[2*p +: 2]), 64'(p % 2));

        // R10: drive-map storage has no side effects
        wr(ra('h28, 0), 32'hDEAD_BEEF);
        wr(ra('h28, 1), 32'hFFFF_FFFF);
        rd(ra('h28, 0), v); chk("R10", "drive-map bank0", 64'(v), 64'hDEAD_BEEF);
        rd(ra('h28, 1), v); chk("R10 R11", "drive-map bank1", 64'(v), 64'hFF);
        chk("R10", "pin_out untouched", 64'(pin_out), 64'(out_m));
        chk("R10", "pin_oe untouched", 64'(pin_oe), 64'(oe_m));
        step(1);

        // R4: input sampling latency
        pin_in = 40'hF0_1234_5678;
        step(1);
        rd(ra('h0C, 0), v); chk("R4", "input after one edge", 64'(v), 64'h0);
        step(1);
        rd(ra('h0C, 0), v); chk("R4", "input bank0", 64'(v), 64'h1234_5678);
        rd(ra('h0C, 1), v); chk("R4", "input bank1", 64'(v), 64'hF0);
        step(1);
        pin_in = '0;
        step(4);
        clear_all();
        rd(ra('h14, 0), v); chk("R8", "pending cleared bank0", 64'(v), 64'h0);
        rd(ra('h14, 1), v); chk("R8", "pending cleared bank1", 64'(v), 64'h0);
        step(1);

        // R6: both-edge sweep over every pin
        wr(ra('h18, 0), 32'hFFFF_FFFF);
        wr(ra('h18, 1), 32'hFFFF_FFFF);
        rd(ra('h18, 1), v); chk("R11", "enable tail masked", 64'(v), 64'hFF);
        step(1);
        for (int p = 0; p < NP; p++) begin
            pin_in[p] = 1'b1;
            step(2);
            rd(ra('h14, p / 32), v); chk("R6", $sformatf("rise pin %0d early", p), 64'(v), 64'h0);
            step(1);
            rd(ra('h14, p / 32), v); chk("R6", $sformatf("rise pin %0d", p), 64'(v), 64'(32'(1) << (p % 32)));
            chk("R9", $sformatf("irq pin %0d", p), 64'(irq), 64'h1);
            step(1);
            wr(ra('h14, p / 32), 32'(1) << (p % 32));
            rd(ra('h14, p / 32), v); chk("R6", $sformatf("held high pin %0d no re-set", p), 64'(v), 64'h0);
            chk("R9", $sformatf("irq low pin %0d", p), 64'(irq), 64'h0);
            step(1);
            pin_in[p] = 1'b0;
            step(3);
            rd(ra('h14, p / 32), v); chk("R6", $sformatf("fall pin %0d", p), 64'(v), 64'(32'(1) << (p % 32)));
            step(1);
            wr(ra('h14, p / 32), 32'(1) << (p % 32));
        end

        // R8: event in the same cycle as a clear, and zero bits in the clear word
        pin_in[7] = 1'b1;
        step(3);
        pin_in[7] = 1'b0;
        step(2);
        wr(ra('h14, 0), 32'(1) << 7);
        rd(ra('h14, 0), v); chk("R8", "event beats clear", 64'(v), 64'(32'(1) << 7));
        step(1);
        wr(ra('h14, 0), 32'(1) << 7);
        rd(ra('h14, 0), v); chk("R8", "later clear", 64'(v), 64'h0);
        step(1);
        pin_in[3] = 1'b1; pin_in[35] = 1'b1;
        step(3);
        wr(ra('h14, 0), 32'(1) << 3);
        rd(ra('h14, 0), v); chk("R8", "selected bit cleared", 64'(v), 64'h0);
        rd(ra('h14, 1), v); chk("R8", "other bank untouched", 64'(v), 64'(32'(1) << 3));
        step(1);
        pin_in[3] = 1'b0; pin_in[35] = 1'b0;
        step(4);
        clear_all();

        // R7: level-high mode on pin 9
        wr(ra('h2C, 0), 32'(1) << 9);
        pin_in[9] = 1'b1;
        step(3);
        rd(ra('h14, 0), v); chk("R7", "level pending", 64'(v), 64'(32'(1) << 9));
        step(1);
        wr(ra('h14, 0), 32'(1) << 9);
        rd(ra('h14, 0), v); chk("R7", "clear while high does not hold", 64'(v), 64'(32'(1) << 9));
        step(1);
        pin_in[9] = 1'b0;
        step(3);
        wr(ra('h14, 0), 32'(1) << 9);
        step(2);
        rd(ra('h14, 0), v); chk("R7", "no set on falling level", 64'(v), 64'h0);
        step(1);

        // R9: identity masking and read-only behaviour
        wr(ra('h18, 0), 32'(1) << 9);
        wr(ra('h18, 1), 32'h0);
        pin_in[2] = 1'b1;
        step(3);
        rd(ra('h1C, 0), v); chk("R9", "identity masked", 64'(v), 64'h0);
        chk("R9", "irq masked", 64'(irq), 64'h0);
        step(1);
        pin_in[9] = 1'b1;
        step(3);
        rd(ra('h1C, 0), v); chk("R9", "identity pin 9", 64'(v), 64'(32'(1) << 9));
        chk("R9", "irq raised", 64'(irq), 64'h1);
        step(1);
        wr(ra('h1C, 0), 32'hFFFF_FFFF);
        rd(ra('h1C, 0), v); chk("R9", "identity write ignored", 64'(v), 64'(32'(1) << 9));
        rd(ra('h14, 0), v); chk("R9", "pending after identity write", 64'(v), 64'((32'(1) << 9) | (32'(1) << 2)));
        step(1);
        wr(ra('h18, 0), 32'h0);
        chk("R9", "irq with no enables", 64'(irq), 64'h0);
        pin_in = '0;
        step(4);
        clear_all();
        wr(ra('h2C, 0), 32'h0);
        rd(ra('h14, 0), v); chk("R7", "pending idle at end", 64'(v), 64'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule